// File: doc/BRIEF.md
# Service-Bus Master Control Register File

This block is the software-visible control store of a serial service-bus master. A host reaches it through a simple word-wide slave port that has separate read and write address lines. Two words hold per-port enable bits. Each enable word can be rewritten whole, or changed through an alias address that only sets bits or only clears bits. This lets software flip single ports without a read-modify-write.

The file also has a read-only identification word, an error-status word that always reads zero, and a command word. Setting either of the two top bits of the command word soft-resets every register. All other words inside the 512-byte window are plain scratch storage. An access that runs past the end of the window does nothing: a write is dropped and a read returns zero.

Top module: `svcbus_ctl_regs`

## Requirements
- R1: After the hardware reset (rst_n low at a clock edge), every word reads 0 except the identification word at byte address 0x074, which reads 0xE0050101. rdata is 0 while reset is held.
- R2: A write to byte address 0x010 replaces enable word 0, and a write to 0x014 replaces enable word 1. Either word reads back at the same address.
- R3: A write to 0x018 ORs wdata into enable word 0, and a write to 0x01C ORs it into enable word 1. The locations 0x018 and 0x01C keep reading 0.
- R4: A write to 0x020 clears the bits of enable word 0 that are 1 in wdata, and a write to 0x024 does the same for enable word 1. Those two locations keep reading 0.
- R5: Writes to 0x074 are ignored, so the identification word keeps reading 0xE0050101.
- R6: Writes to 0x0D0 are ignored, so that location always reads 0 (no errors).
- R7: A write to 0x1D0 with bit 31 (general) or bit 30 (error) set resets every register at the next clock edge. A read issued in the cycle after the command still returns the old data, and a write issued in that cycle is lost. A write to 0x1D0 with neither bit set does nothing, and 0x1D0 always reads 0.
- R8: An access with byte address + 4 > 512 is out of range. An out-of-range write changes no word, and an out-of-range read returns 0.
- R9: Every other in-range word, including the last one at 0x1FC, stores the written data and reads it back unchanged. The word index is the byte address shifted right by 2.
- R10: A read returns data one cycle after rd_en. A read in the same cycle as a write to the same word returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rdata | output | 32 | Read data, registered; holds when rd_en is low |

## Verification
The bench fills every word and then reads every word back. A decoder that let an alias or the identification word store data, or that put a special word at the wrong index, would return the pattern instead of the constant. It attacks the window edge at 0x1FC and 0x1FD: an off-by-one range check would either drop the last word or store a value that should be dropped. It times the soft reset to the cycle. A design that reset a cycle early would lose the read that follows the command, and one that latched the command would keep resetting. It also checks a read and a write to the same word in the same cycle, which catches a read path that bypasses the write.

// File: rtl/svc_regs_pkg.sv
// Package: register indices, reset constants and word classification
// for the service-bus master control register file.
// Assumes 32-bit words and a byte address shifted right by 2 for the index.
package svc_regs_pkg;

    localparam int W_EN0  = 4;    // 0x010
    localparam int W_EN1  = 5;    // 0x014
    localparam int W_SET0 = 6;    // 0x018
    localparam int W_SET1 = 7;    // 0x01C
    localparam int W_CLR0 = 8;    // 0x020
    localparam int W_CLR1 = 9;    // 0x024
    localparam int W_ID   = 29;   // 0x074
    localparam int W_ERR  = 52;   // 0x0D0
    localparam int W_CMD  = 116;  // 0x1D0

    localparam logic [31:0] ID_RESET = 32'hE005_0101;
    localparam int CMD_GEN_BIT = 31;
    localparam int CMD_ERR_BIT = 30;

    typedef enum logic [1:0] {
        K_STORE = 2'd0,
        K_EN    = 2'd1,
        K_CONST = 2'd2
    } word_kind_e;

    // Class of a word index: enable word, fixed constant or plain storage.
    function automatic word_kind_e kind_of(input int idx);
        case (idx)
            W_EN0, W_EN1:                          return K_EN;
            W_SET0, W_SET1, W_CLR0, W_CLR1,
            W_ID, W_ERR, W_CMD:                    return K_CONST;
            default:                               return K_STORE;
        endcase
    endfunction

    // Reset value of a word index.
    function automatic logic [31:0] reset_value(input int idx);
        return (idx == W_ID) ? ID_RESET : 32'h0;
    endfunction

endpackage

// File: rtl/svc_addr_check.sv
// Module: svc_addr_check
// Turns a byte address into a word index and an in-range flag.
// An access counts as in range when address + 4 does not pass the end
// of the window of NUM_WORDS words. Assumes ADDR_W >= IDX_W + 2.
module svc_addr_check #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = NUM_WORDS * 4;

    logic [ADDR_W:0] end_byte;

    // End of the 4-byte access, computed one bit wider so it cannot wrap.
    always_comb begin
        end_byte = {1'b0, addr} + (ADDR_W+1)'(4);
        in_range = (end_byte <= (ADDR_W+1)'(SPAN));
        idx      = addr[IDX_W+1:2];
    end
endmodule

// File: rtl/svc_soft_reset.sv
// Module: svc_soft_reset
// Turns a command-word write that has either reset bit set into a
// one-cycle soft-reset pulse on the following cycle. No new request is
// taken while the pulse is high, so the pulse never lasts two cycles.
module svc_soft_reset (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic req_bits,
    output logic soft_rst
);
    // Register the request; the pulse clears itself after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst <= 1'b0;
        else        soft_rst <= !soft_rst && cmd_wr && req_bits;
    end
endmodule

// File: rtl/svc_reg_array.sv
// Module: svc_reg_array
// Holds the register words. The enable words take direct, OR-alias and
// clear-alias writes. Constant words are wires, not flops. Every other
// word is plain storage. The hardware reset and the soft reset both
// load the reset values, and reset wins over a write in the same cycle.
module svc_reg_array
    import svc_regs_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              soft_rst,
    input  logic                              wr_ok,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
    localparam int SET_OFS = W_SET0 - W_EN0;
    localparam int CLR_OFS = W_CLR0 - W_EN0;

    logic clr_all;
    assign clr_all = !rst_n || soft_rst;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        localparam word_kind_e KIND = kind_of(g);
        localparam logic [DATA_W-1:0] RST = DATA_W'(reset_value(g));

        if (KIND == K_EN) begin : g_en
            logic [DATA_W-1:0] q;
            // Enable word: direct write, OR through set alias, AND-NOT through clear alias.
            always_ff @(posedge clk) begin
                if (clr_all)                                    q <= RST;
                else if (wr_ok && wr_idx == IDX_W'(g))          q <= wdata;
                else if (wr_ok && wr_idx == IDX_W'(g+SET_OFS))  q <= q | wdata;
                else if (wr_ok && wr_idx == IDX_W'(g+CLR_OFS))  q <= q & ~wdata;
            end
            assign words[g] = q;
        end else if (KIND == K_STORE) begin : g_store
            logic [DATA_W-1:0] q;
            // Plain storage word.
            always_ff @(posedge clk) begin
                if (clr_all)                            q <= RST;
                else if (wr_ok && wr_idx == IDX_W'(g))  q <= wdata;
            end
            assign words[g] = q;
        end else begin : g_const
            assign words[g] = RST;
        end
    end
endmodule

// File: rtl/svcbus_ctl_regs.sv
// Module: svcbus_ctl_regs (top)
// Control register file of a serial service-bus master, behind a
// word-wide slave port with separate read and write addresses.
// Reads are registered with one cycle of latency and return 0 when out
// of range. rdata is cleared only by the hardware reset.
module svcbus_ctl_regs
    import svc_regs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic                             wr_in, rd_in, wr_ok, cmd_wr, soft_rst;
    logic [IDX_W-1:0]                 wr_idx, rd_idx;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    svc_addr_check #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_wchk (
        .addr(wr_addr), .in_range(wr_in), .idx(wr_idx)
    );

    svc_addr_check #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_rchk (
        .addr(rd_addr), .in_range(rd_in), .idx(rd_idx)
    );

    assign wr_ok  = wr_en && wr_in;
    assign cmd_wr = wr_ok && (wr_idx == IDX_W'(W_CMD));

    svc_soft_reset u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .req_bits (wdata[CMD_GEN_BIT] | wdata[CMD_ERR_BIT]),
        .soft_rst (soft_rst)
    );

    svc_reg_array #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_ok    (wr_ok),
        .wr_idx   (wr_idx),
        .wdata    (wdata),
        .words    (words)
    );

    // Registered read port: selected word, or 0 when out of range.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_in ? words[rd_idx] : '0;
    end
endmodule

// File: rtl/svc_regs_chk.sv
// Module: svc_regs_chk
// Assertion checker bound to svcbus_ctl_regs. It watches the port and
// the soft-reset pulse between the command decode and the register array.
module svc_regs_chk
    import svc_regs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rdata,
    input logic              soft_rst
);
    localparam int SPAN = NUM_WORDS * 4;

    logic rd_oor;
    assign rd_oor = ({1'b0, rd_addr} + (ADDR_W+1)'(4)) > (ADDR_W+1)'(SPAN);

    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_oor) |=> (rdata == '0));

    p_id_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(W_ID*4)) |=> (rdata == DATA_W'(ID_RESET)));

    p_err_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(W_ERR*4)) |=> (rdata == '0));

    p_set_alias_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_W'(W_SET0*4) || rd_addr == ADDR_W'(W_SET1*4)))
        |=> (rdata == '0));

    p_clr_alias_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_W'(W_CLR0*4) || rd_addr == ADDR_W'(W_CLR1*4)))
        |=> (rdata == '0));

    p_cmd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(W_CMD*4)) |=> (rdata == '0));

    p_srst_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_srst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(wr_en && wr_addr == ADDR_W'(W_CMD*4)
                           && (wdata[CMD_GEN_BIT] || wdata[CMD_ERR_BIT])));
endmodule

bind svcbus_ctl_regs svc_regs_chk #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata), .soft_rst(soft_rst)
);

// File: tb/sim_svcbus_ctl_regs.sv
`timescale 1ns/1ps
module sim_svcbus_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [128];

    svcbus_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata)
    );

    always #4 clk = ~clk;

    function automatic void model_reset();
        for (int i = 0; i < 128; i++) model[i] = (i == 29) ? 32'hE005_0101 : 32'h0;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a > 12'd508) return 32'h0;
        return model[a[8:2]];
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        int idx;
        if (a > 12'd508) return;
        idx = int'(a[8:2]);
        case (idx)
            4, 5:    model[idx] = d;
            6, 7:    model[idx-2] = model[idx-2] | d;
            8, 9:    model[idx-4] = model[idx-4] & ~d;
            29, 52:  ;
            116:     if (d[31] || d[30]) model_reset();
            default: model[idx] = d;
        endcase
    endfunction

    function automatic string req_of(int idx);
        case (idx)
            4, 5:   return "R2";
            6, 7:   return "R3";
            8, 9:   return "R4";
            29:     return "R5";
            52:     return "R6";
            116:    return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] pattern(int i);
        return (32'(i) * 32'h0103_0507) ^ 32'h5A5A_A5A5;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        if (a == 12'h1D0 && (d[31] || d[30])) @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a, string req);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, model_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] old;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every word, then window edges (R8)
        for (int i = 0; i < 128; i++) rd(12'(i*4), "R1");
        rd(12'h200, "R8");
        rd(12'hFFC, "R8");

        // Fill every word except the command word, then sweep reads
        for (int i = 0; i < 128; i++) if (i != 116) wr(12'(i*4), pattern(i));
        for (int i = 0; i < 128; i++) rd(12'(i*4), req_of(i));

        // R2 / R3 / R4: direct, set-alias and clear-alias on both enable words
        wr(12'h010, 32'hF0F0_0F0F); rd(12'h010, "R2");
        wr(12'h018, 32'h0000_F0F0); rd(12'h010, "R3"); rd(12'h018, "R3");
        wr(12'h020, 32'hF000_000F); rd(12'h010, "R4"); rd(12'h020, "R4");
        wr(12'h014, 32'h0000_0000); rd(12'h014, "R2");
        wr(12'h01C, 32'h8000_0001); rd(12'h014, "R3"); rd(12'h01C, "R3");
        wr(12'h024, 32'h0000_0001); rd(12'h014, "R4"); rd(12'h024, "R4");

        // R5 / R6: writes to read-only words are ignored
        wr(12'h074, 32'h1234_5678); rd(12'h074, "R5");
        wr(12'h0D0, 32'hFFFF_FFFF); rd(12'h0D0, "R6");

        // R8 / R9: the window edge
        wr(12'h1FC, 32'hCAFE_F00D); rd(12'h1FC, "R9");
        wr(12'h1FD, 32'hDEAD_BEEF); rd(12'h1FC, "R8"); rd(12'h1FD, "R8");
        wr(12'h800, 32'h0BAD_0BAD); rd(12'h000, "R8");
        wr(12'h1F9, 32'h0F1E_2D3C); rd(12'h1F8, "R9");

        // R10: a read and a write to the same word in one cycle return the old value
        old = model_read(12'h040);
        wr_en = 1'b1; wr_addr = 12'h040; wdata = 32'h2468_ACE0;
        rd_en = 1'b1; rd_addr = 12'h040;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10", rdata, old);
        model_write(12'h040, 32'h2468_ACE0);
        rd(12'h040, "R10");

        // R7: a command without the reset bits does nothing
        wr(12'h1D0, 32'h3FFF_FFFF); rd(12'h040, "R7"); rd(12'h1D0, "R7");

        // R7: general reset timing; the read in the next cycle still sees old data
        old = model_read(12'h040);
        wr_en = 1'b1; wr_addr = 12'h1D0; wdata = 32'h8000_0000;
        @(negedge clk);
        wr_addr = 12'h044; wdata = 32'h1111_1111;
        rd_en = 1'b1; rd_addr = 12'h040;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7", rdata, old);
        model_reset();
        rd(12'h044, "R7");
        for (int i = 0; i < 128; i++) rd(12'(i*4), "R7");

        // R7: the error-reset bit alone also resets
        wr(12'h0C0, 32'h0000_0077); wr(12'h010, 32'h0000_00FF);
        rd(12'h0C0, "R9");
        wr(12'h1D0, 32'h4000_0000);
        rd(12'h0C0, "R7"); rd(12'h010, "R7"); rd(12'h074, "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule